// File: doc/BRIEF.md
# ULPI PHY Function Control Register

This block is the PHY-side function control register of a ULPI transceiver. It holds one 8-bit control value that the link reaches through ULPI register accesses at three adjacent addresses. A write to the first address loads the value. A write to the second ORs the data into it. A write to the third clears every bit that is set in the data. All three addresses return the same value when read. The register fields are decoded into simple control outputs: transceiver speed and low-speed preamble, termination, operating mode and low-power state.

A bit in the register requests a transceiver reset, and that bit clears itself. The block runs the direction handshake for it. It owns DIR while the reset runs, releases DIR for one cycle, then reasserts DIR for one cycle to request an RX CMD status update. The suspend bit is active low. When the PHY leaves low-power mode, hardware sets it back to powered, and this set wins over any write in the same cycle. An asynchronous power-on reset returns every field to its reset value.

Top module: `ulpi_fctl`

## Requirements
- R1: After power-on reset, the register reads 0x41: speed field (bits 1:0) = 01, termination bit 2 = 0, operating mode (bits 4:3) = 00, reset bit 5 = 0, suspend bit 6 = 1, bit 7 = 0. The outputs show full-speed, powered, DIR low and no RX CMD request.
- R2: With BASE_ADDR = 0x04, a write to 0x04 loads the data. A write to 0x05 ORs the data in. A write to 0x06 clears the bits that are set in the data. Reads at 0x04, 0x05 and 0x06 all return the register. Any other address reads 0, and writes to it have no effect.
- R3: Bit 7 always reads 0, and writes cannot set it.
- R4: The speed field decodes as follows: 00 drives xcvr_hs; 01 drives xcvr_fs; 10 drives xcvr_ls; 11 drives xcvr_fs together with ls_preamble.
- R5: Bit 2 drives term_sel. The mode field decodes as follows: 01 drives tx_nondrive, 10 drives coding_bypass, 11 drives sync_eop_bypass, and 00 drives none of them.
- R6: Setting bit 5 at a clock edge starts the handshake at the next edge. From then, dir_req and xcvr_rst are high for HOLD_CYC cycles. Next, dir_req is low for one cycle, and bit 5 reads 0 from that cycle on. Next, dir_req and rxcmd_req are high for one cycle. After that, dir_req is low.
- R7: While bit 5 is set or the handshake is in progress, register writes are ignored. The handshake changes no field other than bit 5.
- R8: Bit 6 = 0 drives low_power high. A one-cycle lp_exit pulse sets bit 6 at that same edge, even when a write at that edge clears bit 6.
- R9: Asserting rst_n low restores the reset value at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address, used for both reads and writes |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| lp_exit | input | 1 | Pulse marking the exit from low-power mode |
| xcvr_hs | output | 1 | High-speed transceiver selected |
| xcvr_fs | output | 1 | Full-speed transceiver selected |
| xcvr_ls | output | 1 | Low-speed transceiver selected |
| ls_preamble | output | 1 | Full-speed preamble added before low-speed packets |
| term_sel | output | 1 | Termination select |
| tx_nondrive | output | 1 | Non-driving operating mode |
| coding_bypass | output | 1 | Bit stuffing and NRZI disabled |
| sync_eop_bypass | output | 1 | No automatic SYNC/EOP |
| low_power | output | 1 | Low-power mode requested |
| xcvr_rst | output | 1 | Transceiver reset in progress |
| dir_req | output | 1 | Request to drive ULPI DIR high |
| rxcmd_req | output | 1 | One-cycle RX CMD update request |

## Verification
Register writes and the lp_exit set show up after one clock edge. The decoded outputs and rd_data follow the register without further delay. The bench therefore drives each stimulus on a falling edge and samples on the next falling edge. The handshake starts one edge after bit 5 is written. The bench samples each cycle of the window (hold for HOLD_CYC cycles, one-cycle gap, one-cycle RX CMD, then idle) on its own falling edge and compares it with the expected phase. It also injects a write during the hold, checks that the write had no effect, and checks that bit 5 is already 0 in the gap cycle. The asynchronous reset is checked between clock edges.

// File: rtl/ulpi_fctl_pkg.sv
package ulpi_fctl_pkg;

    localparam int REG_W = 8;

    // bit positions inside the control register
    localparam int B_SPD_LO = 0;
    localparam int B_TERM   = 2;
    localparam int B_OPM_LO = 3;
    localparam int B_SRST   = 5;
    localparam int B_SUSPN  = 6;
    localparam int B_RSVD   = 7;

    localparam logic [REG_W-1:0] CTRL_RESET = 8'h41;

    typedef enum logic [1:0] {
        SPD_HS     = 2'b00,
        SPD_FS     = 2'b01,
        SPD_LS     = 2'b10,
        SPD_FS_PRE = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        OPM_NORMAL  = 2'b00,
        OPM_NODRIVE = 2'b01,
        OPM_RAW     = 2'b10,
        OPM_NOSYNC  = 2'b11
    } opmode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_HOLD,
        SEQ_GAP,
        SEQ_RXCMD
    } seq_state_e;

endpackage

// File: rtl/ulpi_fctl_regfile.sv
module ulpi_fctl_regfile
    import ulpi_fctl_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              lock,
    input  logic              clr_srst,
    input  logic              lp_exit,
    output logic [REG_W-2:0]  ctrl_live,
    output logic [REG_W-1:0]  rd_data
);

    localparam logic [ADDR_W-1:0] A_LOAD = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_SET  = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CLR  = BASE_ADDR + ADDR_W'(2);

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
    } rf_t;

    rf_t rf_d, rf_q;
    logic hit;

    always_comb begin
        rf_d = rf_q;
        hit  = (addr == A_LOAD) || (addr == A_SET) || (addr == A_CLR);
        if (wr_en && !lock) begin
            if (addr == A_LOAD)     rf_d.ctrl = wdata;
            else if (addr == A_SET) rf_d.ctrl = rf_q.ctrl | wdata;
            else if (addr == A_CLR) rf_d.ctrl = rf_q.ctrl & ~wdata;
        end
        if (clr_srst) rf_d.ctrl[B_SRST]  = 1'b0;
        if (lp_exit)  rf_d.ctrl[B_SUSPN] = 1'b1;
        rf_d.ctrl[B_RSVD] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '{ctrl: CTRL_RESET};
        else        rf_q <= rf_d;
    end

    assign ctrl_live = rf_q.ctrl[REG_W-2:0];
    assign rd_data   = hit ? rf_q.ctrl : '0;

endmodule

// File: rtl/ulpi_fctl_rstseq.sv
module ulpi_fctl_rstseq
    import ulpi_fctl_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_bit,
    output logic busy,
    output logic clr_srst,
    output logic xcvr_rst,
    output logic dir_req,
    output logic rxcmd_req
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        clr_srst = 1'b0;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (srst_bit) begin
                    seq_d.st  = SEQ_HOLD;
                    seq_d.cnt = CNT_LOAD;
                end
            end
            SEQ_HOLD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = SEQ_GAP;
                    clr_srst = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            SEQ_GAP:   seq_d.st = SEQ_RXCMD;
            SEQ_RXCMD: seq_d.st = SEQ_IDLE;
            default:   seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = srst_bit || (seq_q.st != SEQ_IDLE);
    assign xcvr_rst  = (seq_q.st == SEQ_HOLD);
    assign dir_req   = (seq_q.st == SEQ_HOLD) || (seq_q.st == SEQ_RXCMD);
    assign rxcmd_req = (seq_q.st == SEQ_RXCMD);

endmodule

// File: rtl/ulpi_fctl_decode.sv
module ulpi_fctl_decode
    import ulpi_fctl_pkg::*;
(
    input  logic [1:0] speed,
    input  logic       term_bit,
    input  logic [1:0] opmode,
    input  logic       suspend_n,
    output logic       xcvr_hs,
    output logic       xcvr_fs,
    output logic       xcvr_ls,
    output logic       ls_preamble,
    output logic       term_sel,
    output logic       tx_nondrive,
    output logic       coding_bypass,
    output logic       sync_eop_bypass,
    output logic       low_power
);

    speed_e  spd;
    opmode_e opm;

    always_comb begin
        spd             = speed_e'(speed);
        opm             = opmode_e'(opmode);
        xcvr_hs         = (spd == SPD_HS);
        xcvr_fs         = (spd == SPD_FS) || (spd == SPD_FS_PRE);
        xcvr_ls         = (spd == SPD_LS);
        ls_preamble     = (spd == SPD_FS_PRE);
        term_sel        = term_bit;
        tx_nondrive     = (opm == OPM_NODRIVE);
        coding_bypass   = (opm == OPM_RAW);
        sync_eop_bypass = (opm == OPM_NOSYNC);
        low_power       = !suspend_n;
    end

endmodule

// File: rtl/ulpi_fctl.sv
module ulpi_fctl
    import ulpi_fctl_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h04,
    parameter int                HOLD_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    input  logic              lp_exit,
    output logic              xcvr_hs,
    output logic              xcvr_fs,
    output logic              xcvr_ls,
    output logic              ls_preamble,
    output logic              term_sel,
    output logic              tx_nondrive,
    output logic              coding_bypass,
    output logic              sync_eop_bypass,
    output logic              low_power,
    output logic              xcvr_rst,
    output logic              dir_req,
    output logic              rxcmd_req
);

    logic [REG_W-2:0] ctrl;
    logic             busy;
    logic             clr_srst;

    ulpi_fctl_regfile #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .lock      (busy),
        .clr_srst  (clr_srst),
        .lp_exit   (lp_exit),
        .ctrl_live (ctrl),
        .rd_data   (rd_data)
    );

    ulpi_fctl_rstseq #(
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_bit  (ctrl[B_SRST]),
        .busy      (busy),
        .clr_srst  (clr_srst),
        .xcvr_rst  (xcvr_rst),
        .dir_req   (dir_req),
        .rxcmd_req (rxcmd_req)
    );

    ulpi_fctl_decode u_dec (
        .speed           (ctrl[B_SPD_LO +: 2]),
        .term_bit        (ctrl[B_TERM]),
        .opmode          (ctrl[B_OPM_LO +: 2]),
        .suspend_n       (ctrl[B_SUSPN]),
        .xcvr_hs         (xcvr_hs),
        .xcvr_fs         (xcvr_fs),
        .xcvr_ls         (xcvr_ls),
        .ls_preamble     (ls_preamble),
        .term_sel        (term_sel),
        .tx_nondrive     (tx_nondrive),
        .coding_bypass   (coding_bypass),
        .sync_eop_bypass (sync_eop_bypass),
        .low_power       (low_power)
    );

endmodule

// File: rtl/ulpi_fctl_chk.sv
module ulpi_fctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       lp_exit,
    input logic [7:0] rd_data,
    input logic       xcvr_hs,
    input logic       xcvr_fs,
    input logic       xcvr_ls,
    input logic       term_sel,
    input logic       low_power,
    input logic       xcvr_rst,
    input logic       dir_req,
    input logic       rxcmd_req
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0); // R3

    AST_SPEED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({xcvr_hs, xcvr_fs, xcvr_ls})); // R4

    AST_WAKE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        lp_exit |=> !low_power); // R8

    AST_HOLD_OWNS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_rst |-> dir_req); // R6

    AST_RXCMD_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rxcmd_req |-> (dir_req && !$past(dir_req))); // R6

    AST_RXCMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rxcmd_req |=> (!rxcmd_req && !dir_req)); // R6

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && xcvr_rst) |=> ($stable(term_sel) && $stable(xcvr_hs)
                                 && $stable(xcvr_fs) && $stable(xcvr_ls))); // R7

endmodule

bind ulpi_fctl ulpi_fctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .lp_exit   (lp_exit),
    .rd_data   (rd_data),
    .xcvr_hs   (xcvr_hs),
    .xcvr_fs   (xcvr_fs),
    .xcvr_ls   (xcvr_ls),
    .term_sel  (term_sel),
    .low_power (low_power),
    .xcvr_rst  (xcvr_rst),
    .dir_req   (dir_req),
    .rxcmd_req (rxcmd_req)
);

// File: tb/sim_ulpi_fctl.sv
`timescale 1ns/1ps
module sim_ulpi_fctl;

    localparam int HOLD = 5;
    localparam int NV   = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = 6'h04;
    logic [7:0] wdata = '0;
    logic       lp_exit = 1'b0;
    logic [7:0] rd_data;
    logic xcvr_hs, xcvr_fs, xcvr_ls, ls_preamble, term_sel, tx_nondrive;
    logic coding_bypass, sync_eop_bypass, low_power, xcvr_rst, dir_req, rxcmd_req;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ulpi_fctl #(.ADDR_W(6), .BASE_ADDR(6'h04), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .lp_exit(lp_exit), .xcvr_hs(xcvr_hs), .xcvr_fs(xcvr_fs),
        .xcvr_ls(xcvr_ls), .ls_preamble(ls_preamble), .term_sel(term_sel),
        .tx_nondrive(tx_nondrive), .coding_bypass(coding_bypass),
        .sync_eop_bypass(sync_eop_bypass), .low_power(low_power),
        .xcvr_rst(xcvr_rst), .dir_req(dir_req), .rxcmd_req(rxcmd_req)
    );

    // {address, write data, expected register value afterwards}
    localparam logic [21:0] VEC [NV] = '{
        {6'h04, 8'h00, 8'h00},   // R2 load, R4 high-speed, R8 low power
        {6'h05, 8'h40, 8'h40},   // R2 set
        {6'h05, 8'h02, 8'h42},   // R4 low-speed
        {6'h05, 8'h01, 8'h43},   // R4 fs + preamble
        {6'h05, 8'h04, 8'h47},   // R5 termination
        {6'h05, 8'h08, 8'h4F},   // R5 non-driving
        {6'h06, 8'h08, 8'h47},   // R2 clear
        {6'h05, 8'h10, 8'h57},   // R5 coding bypass
        {6'h05, 8'h08, 8'h5F},   // R5 no sync/eop
        {6'h06, 8'h18, 8'h47},   // R5 normal
        {6'h04, 8'hDF, 8'h5F},   // R3 bit 7 dropped on load
        {6'h05, 8'h80, 8'h5F},   // R3 bit 7 dropped on set
        {6'h08, 8'h00, 8'h5F},   // R2 foreign address ignored
        {6'h06, 8'h43, 8'h1C},   // R2 clear several
        {6'h04, 8'h41, 8'h41}    // R2 back to default
    };

    function automatic logic [8:0] exp_outs(input logic [7:0] r);
        return {r[1:0] == 2'b00, r[1:0] == 2'b01 || r[1:0] == 2'b11,
                r[1:0] == 2'b10, r[1:0] == 2'b11, r[2],
                r[4:3] == 2'b01, r[4:3] == 2'b10, r[4:3] == 2'b11, !r[6]};
    endfunction

    function automatic logic [8:0] got_outs();
        return {xcvr_hs, xcvr_fs, xcvr_ls, ls_preamble, term_sel,
                tx_nondrive, coding_bypass, sync_eop_bypass, low_power};
    endfunction

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
        addr = a;
        #0.5;
        check(req, {1'b0, rd_data}, {1'b0, exp});
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d, input logic wake);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; lp_exit = wake;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; lp_exit = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #5 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_chk("R1", 6'h04, 8'h41);
        check("R1", got_outs(), exp_outs(8'h41));
        check("R1", {7'b0, dir_req, rxcmd_req}, 9'b0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][21:16], VEC[i][15:8], 1'b0);
            read_chk("R2", 6'h04 + 6'(i % 3), VEC[i][7:0]);
            check("R4/R5", got_outs(), exp_outs(VEC[i][7:0]));
        end
        read_chk("R2", 6'h07, 8'h00);
        read_chk("R2", 6'h03, 8'h00);

        // R6 / R7 reset handshake
        do_write(6'h05, 8'h20, 1'b0);
        read_chk("R6", 6'h06, 8'h61);
        check("R6", {7'b0, dir_req, rxcmd_req}, 9'b0);
        for (int k = 1; k <= HOLD + 3; k++) begin
            if (k == 2) begin
                wr_en = 1'b1; addr = 6'h04; wdata = 8'h04;
            end
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            if (k <= HOLD)
                check("R6", {6'b0, xcvr_rst, dir_req, rxcmd_req}, 9'b110);
            else if (k == HOLD + 1) begin
                check("R6", {6'b0, xcvr_rst, dir_req, rxcmd_req}, 9'b000);
                read_chk("R6", 6'h04, 8'h41);
            end else if (k == HOLD + 2)
                check("R6", {6'b0, xcvr_rst, dir_req, rxcmd_req}, 9'b011);
            else
                check("R6", {6'b0, xcvr_rst, dir_req, rxcmd_req}, 9'b000);
        end
        read_chk("R7", 6'h04, 8'h41);
        check("R7", got_outs(), exp_outs(8'h41));

        // R8 suspend and wake
        do_write(6'h06, 8'h40, 1'b0);
        read_chk("R8", 6'h04, 8'h01);
        check("R8", {8'b0, low_power}, 9'd1);
        @(negedge clk); lp_exit = 1'b1;
        @(posedge clk); @(negedge clk); lp_exit = 1'b0;
        read_chk("R8", 6'h04, 8'h41);
        do_write(6'h06, 8'h40, 1'b1);
        read_chk("R8", 6'h05, 8'h41);
        check("R8", {8'b0, low_power}, 9'd0);

        // R9 asynchronous reset
        do_write(6'h04, 8'h5E, 1'b0);
        read_chk("R9", 6'h04, 8'h5E);
        #0.5 rst_n = 1'b0;
        #0.3;
        check("R9", {1'b0, rd_data}, {1'b0, 8'h41});
        @(negedge clk); rst_n = 1'b1;
        read_chk("R9", 6'h06, 8'h41);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule